// File: doc/BRIEF.md
# Eight-Pin Bidirectional Port with Direction and Digital-Enable Control

This block is one general-purpose I/O port of eight pins, placed behind a simple synchronous register bus. The bus has one write strobe, a byte offset, write data and a combinational read data path. Software picks the direction of each pin and sets the levels that output pins drive. When it reads the data register, it gets the output latch for output pins and the synchronized pad level for input pins.

Some pins are shared with analog converter channels. For that case the port has a per-pin digital-enable register. An input pin whose enable bit is clear counts as analog, and it reads as 0. A pull-up register asks the pad to pull up, but only on pins that are inputs.

The block has no state machine. It is four registers, a synchronizer and a read selector. The optional registers are chosen by parameter. With `ANALOG_SHARED` = 0, every input pin counts as digitally enabled and offset 0x04 reads 0. With `HAS_PULLUP` = 0, offset 0x06 reads 0 and no pull-up is ever requested.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, digital-enable, pull-up and output-latch registers are 0, so `pad_oe`, `pad_out` and `pad_pu` are all 0 and every mapped offset reads 0.
- R2: The direction register is at offset 0x02. A bit written as 1 makes that pin an output (`pad_oe` bit high) from the clock edge of the write, and a 0 makes it an input. For example, 0xF0 makes pins 7..4 outputs and pins 3..0 inputs.
- R3: The output latch is at offset 0x00. A write loads it on the clock edge of the write, and `pad_out` carries it unchanged until the next write to offset 0x00.
- R4: A read of offset 0x00 returns the latch value on every bit whose direction bit is 1.
- R5: A read of offset 0x00 returns the pad level on every input bit whose digital-enable bit is 1. The pad level passes through two flops, so a pad change becomes visible after the second rising clock edge and not after the first.
- R6: A read of offset 0x00 returns 0 on every input bit whose digital-enable bit is 0, whatever the pad level.
- R7: The digital-enable register (offset 0x04), the pull-up register (offset 0x06) and the direction register read back the value last written to them.
- R8: `pad_pu` bit i is high only when pull-up bit i is 1 and direction bit i is 0.
- R9: Offsets other than 0x00, 0x02, 0x04 and 0x06 read 0. Writes to those offsets change no register.
- R10: A write to offset 0x00 updates the latch on input pins too. The written value appears on `pad_out` and is read back once those pins are turned to outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_addr | input | 8 | Byte offset of the register accessed |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pad_in | input | 8 | Levels seen at the pins |
| pad_out | output | 8 | Output latch driven toward the pins |
| pad_oe | output | 8 | Per-pin output enable (1 = drive) |
| pad_pu | output | 8 | Per-pin pull-up request |

## Verification
The bench goes after the mixed read of offset 0x00, using patterns where outputs, enabled inputs and disabled inputs sit side by side. A design that swapped the masks, or ignored the digital enable, would return latch bits on input pins or leak pad levels onto analog pins. Synchronizer latency is checked at both edges: a design with one flop fewer would show the new level after the first edge, and one with an extra flop would miss it after the second. Writes to unmapped offsets and writes to the latch while pins are inputs are checked by reading back. A decoder that aliased offsets would corrupt a register, and a latch gated by direction would lose the value written earlier.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    localparam int unsigned PORT_W = 8;
    localparam int unsigned OFS_W  = 8;

    typedef enum logic [OFS_W-1:0] {
        OFS_LATCH = 8'h00,
        OFS_DIR   = 8'h02,
        OFS_DEN   = 8'h04,
        OFS_PULL  = 8'h06
    } reg_ofs_e;
endpackage

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= raw_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

    // R5: first stage captures the pad value of the previous edge
    assert_first_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> stage_q[0] == $past(raw_i));
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH         = 8,
    parameter bit          ANALOG_SHARED = 1'b1,
    parameter bit          HAS_PULLUP    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [OFS_W-1:0] addr_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] latch_o,
    output logic [WIDTH-1:0] dir_o,
    output logic [WIDTH-1:0] den_o,
    output logic [WIDTH-1:0] pull_o
);
    logic hit_latch, hit_dir, hit_den, hit_pull;

    always_comb begin
        hit_latch = wr_i && (addr_i == OFS_LATCH);
        hit_dir   = wr_i && (addr_i == OFS_DIR);
        hit_den   = wr_i && (addr_i == OFS_DEN);
        hit_pull  = wr_i && (addr_i == OFS_PULL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_o <= '0;
            dir_o   <= '0;
        end else begin
            if (hit_latch) latch_o <= wdata_i;
            if (hit_dir)   dir_o   <= wdata_i;
        end
    end

    generate
        if (ANALOG_SHARED) begin : g_den
            logic [WIDTH-1:0] den_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)       den_q <= '0;
                else if (hit_den) den_q <= wdata_i;
            end
            assign den_o = den_q;
        end else begin : g_no_den
            assign den_o = '1;
        end

        if (HAS_PULLUP) begin : g_pull
            logic [WIDTH-1:0] pull_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        pull_q <= '0;
                else if (hit_pull) pull_q <= wdata_i;
            end
            assign pull_o = pull_q;
        end else begin : g_no_pull
            assign pull_o = '0;
        end
    endgenerate

    // R2: a direction write shows up on the direction register next cycle
    assert_dir_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i == OFS_DIR) |=> dir_o == $past(wdata_i));

    // R3: the latch holds when no write targets it
    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_i && addr_i == OFS_LATCH) |=> $stable(latch_o));

    // R9: unmapped writes leave direction and latch untouched
    assert_unmapped_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && addr_i != OFS_LATCH && addr_i != OFS_DIR &&
         addr_i != OFS_DEN && addr_i != OFS_PULL) |=> ($stable(dir_o) && $stable(latch_o)));
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH         = 8,
    parameter bit          ANALOG_SHARED = 1'b1
) (
    input  logic [OFS_W-1:0] addr_i,
    input  logic [WIDTH-1:0] latch_i,
    input  logic [WIDTH-1:0] dir_i,
    input  logic [WIDTH-1:0] den_i,
    input  logic [WIDTH-1:0] pull_i,
    input  logic [WIDTH-1:0] pin_sync_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [WIDTH-1:0] port_view;
    logic [WIDTH-1:0] den_view;

    always_comb begin
        port_view = (latch_i & dir_i) | (pin_sync_i & ~dir_i & den_i);
        den_view  = ANALOG_SHARED ? den_i : '0;
        unique case (addr_i)
            OFS_LATCH: rdata_o = port_view;
            OFS_DIR:   rdata_o = dir_i;
            OFS_DEN:   rdata_o = den_view;
            OFS_PULL:  rdata_o = pull_i;
            default:   rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH         = PORT_W,
    parameter int unsigned SYNC_STAGES   = 2,
    parameter bit          ANALOG_SHARED = 1'b1,
    parameter bit          HAS_PULLUP    = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [OFS_W-1:0] bus_addr,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] bus_rdata,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_oe,
    output logic [WIDTH-1:0] pad_pu
);
    logic [WIDTH-1:0] latch_q, dir_q, den_q, pull_q, pin_s;

    gpio_port_regs #(
        .WIDTH(WIDTH), .ANALOG_SHARED(ANALOG_SHARED), .HAS_PULLUP(HAS_PULLUP)
    ) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(bus_wr), .addr_i(bus_addr),
        .wdata_i(bus_wdata), .latch_o(latch_q), .dir_o(dir_q),
        .den_o(den_q), .pull_o(pull_q)
    );

    gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .raw_i(pad_in), .sync_o(pin_s)
    );

    gpio_read_mux #(.WIDTH(WIDTH), .ANALOG_SHARED(ANALOG_SHARED)) rmux_i (
        .addr_i(bus_addr), .latch_i(latch_q), .dir_i(dir_q), .den_i(den_q),
        .pull_i(pull_q), .pin_sync_i(pin_s), .rdata_o(bus_rdata)
    );

    assign pad_out = latch_q;
    assign pad_oe  = dir_q;
    assign pad_pu  = pull_q & ~dir_q;

    // R8: no pin is pulled up while it drives
    always_comb begin
        if (rst_n) assert_pull_on_inputs_R8: assert ((pad_pu & pad_oe) == '0);
    end

    // R6: analog input pins never read as 1 at offset 0x00
    always_comb begin
        if (rst_n && bus_addr == OFS_LATCH)
            assert_analog_reads_zero_R6: assert ((bus_rdata & ~pad_oe & ~den_q) == '0);
    end

    // R1: outputs are quiet the cycle after reset releases
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pad_oe == '0 && pad_out == '0 && pad_pu == '0));
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'h00;
    logic [7:0] pad_out, pad_oe, pad_pu;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    // columns: direction, digital enable, latch, pad level, expected offset-0 read
    localparam logic [7:0] VEC [0:6][0:4] = '{
        '{8'hF0, 8'h0F, 8'hA5, 8'h3C, 8'hAC},
        '{8'hFF, 8'h00, 8'h5A, 8'hFF, 8'h5A},
        '{8'h00, 8'hFF, 8'h77, 8'h96, 8'h96},
        '{8'h00, 8'h00, 8'h77, 8'hFF, 8'h00},
        '{8'h0F, 8'hF0, 8'hC3, 8'h5A, 8'h53},
        '{8'h55, 8'hAA, 8'h00, 8'hFF, 8'hAA},
        '{8'hAA, 8'h0F, 8'hFF, 8'h0F, 8'hAF}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_out", pad_out, 8'h00);
        chk("R1 pad_pu", pad_pu, 8'h00);
        rd(8'h02, r); chk("R1 dir", r, 8'h00);
        rd(8'h04, r); chk("R1 den", r, 8'h00);
        rd(8'h06, r); chk("R1 pull", r, 8'h00);

        // vector walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 7; i++) begin
            wr(8'h02, VEC[i][0]);
            wr(8'h04, VEC[i][1]);
            wr(8'h00, VEC[i][2]);
            pad_in = VEC[i][3];
            repeat (3) @(negedge clk);
            chk("R2 pad_oe", pad_oe, VEC[i][0]);
            chk("R3 pad_out", pad_out, VEC[i][2]);
            rd(8'h00, r); chk("R4/R5/R6 data read", r, VEC[i][4]);
            rd(8'h02, r); chk("R7 dir readback", r, VEC[i][0]);
            rd(8'h04, r); chk("R7 den readback", r, VEC[i][1]);
        end

        // R3 hold across idle cycles
        repeat (5) @(negedge clk);
        chk("R3 latch held", pad_out, 8'hFF);

        // R5 synchronizer latency
        wr(8'h02, 8'h00);
        wr(8'h04, 8'hFF);
        pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'hFF;
        @(negedge clk);
        rd(8'h00, r); chk("R5 after one edge", r, 8'h00);
        @(negedge clk);
        rd(8'h00, r); chk("R5 after two edges", r, 8'hFF);

        // R10 latch written while inputs
        pad_in = 8'h00;
        wr(8'h00, 8'h3C);
        repeat (3) @(negedge clk);
        rd(8'h00, r); chk("R10 inputs read pins", r, 8'h00);
        chk("R10 pad_out carries latch", pad_out, 8'h3C);
        wr(8'h02, 8'hFF);
        rd(8'h00, r); chk("R10 latch read after turn", r, 8'h3C);

        // R7 R8 pull-up
        wr(8'h02, 8'hF0);
        wr(8'h06, 8'hFF);
        rd(8'h06, r); chk("R7 pull readback", r, 8'hFF);
        chk("R8 pull only on inputs", pad_pu, 8'h0F);
        wr(8'h06, 8'h00);
        chk("R8 pull cleared", pad_pu, 8'h00);

        // R9 unmapped offsets
        wr(8'h01, 8'hFF);
        wr(8'h03, 8'h00);
        wr(8'h07, 8'hFF);
        wr(8'h82, 8'h0F);
        rd(8'h01, r); chk("R9 unmapped read", r, 8'h00);
        rd(8'h03, r); chk("R9 unmapped read", r, 8'h00);
        rd(8'h02, r); chk("R9 dir unchanged", r, 8'hF0);
        rd(8'h06, r); chk("R9 pull unchanged", r, 8'h00);
        rd(8'h04, r); chk("R9 den unchanged", r, 8'hFF);
        chk("R9 latch unchanged", pad_out, 8'h3C);

        // R1 reset again mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 oe after re-reset", pad_oe, 8'h00);
        chk("R1 out after re-reset", pad_out, 8'h00);
        rd(8'h04, r); chk("R1 den after re-reset", r, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule